// File: doc/BRIEF.md
# Sequential Multi-Channel Byte Mover

This block copies bytes between a 24-bit memory space (the "A" side) and a bank of 256 peripheral registers selected by an 8-bit address (the "B" side). It has eight channels. Each channel holds a start address on each side, a byte count and a control byte. The control byte picks the direction, the way the A address moves after each byte, and the pattern of B registers that the bytes visit.

Software fills in the channel settings and then writes a start mask with one bit per channel. The block runs the requested channels one at a time, from the lowest number to the highest, and moves one byte per clock. While any requested channel is unfinished it holds a halt line that keeps the processor stopped. Both sides are assumed to answer reads in the same cycle, so each moved byte needs exactly one read strobe and one write strobe in that cycle.

Top module: `dma_seq_engine`

## Requirements
- R1: After reset, `cpu_halt` is low, `chan_pending` is zero and all four bus strobes are low.
- R2: Setting writes use `cfg_addr[6:4]` as the channel and `cfg_addr[3:0]` as the field. Field 0 is the control byte, field 1 is the B base, fields 2/3/4 are A address bits 7:0/15:8/23:16, and fields 5/6 are count bits 7:0/15:8. Field values 7 to 15 change nothing.
- R3: A write on `go_we` loads `chan_pending` with `go_data` (bit n is channel n). `cpu_halt` is high exactly while `chan_pending` is non-zero. Set channels run lowest number first. Each channel gets one idle cycle and then moves one byte per cycle.
- R4: A channel's pending bit clears at the clock edge that ends its last byte. Pending bits are never set except by `go_we`.
- R5: Control bit 7 chooses the direction. With 0, `a_rd` and `b_wr` pulse together and `b_wdata` equals `a_rdata`. With 1, `b_rd` and `a_wr` pulse together and `a_wdata` equals `b_rdata`.
- R6: Control bits 4:3 choose the A step after each byte: 00 adds one, 10 subtracts one, and 01 or 11 keeps the address fixed. The address wraps modulo 2^24.
- R7: Control bits 2:0 give the offset added (mod 256) to the B base for the k-th byte of a channel, with k counting from 0. Codes 0, 2 and 6 add 0. Codes 1 and 5 add k mod 2. Codes 3 and 7 add (k/2) mod 2. Code 4 adds k mod 4.
- R8: A channel moves exactly the programmed count of bytes. A count of 0 moves 65536 bytes.
- R9: A transfer leaves the channel settings unchanged, so starting the same channel again repeats the same bus sequence.
- R10: A start write with `go_data` equal to zero starts nothing, and `cpu_halt` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 7 | Channel (6:4) and field (3:0) |
| cfg_wdata | input | 8 | Settings write byte |
| go_we | input | 1 | Start mask write strobe |
| go_data | input | 8 | Start mask, bit n is channel n |
| cpu_halt | output | 1 | Holds the processor while work is pending |
| chan_pending | output | 8 | Channels still waiting or running |
| a_addr | output | 24 | A side address |
| a_rd | output | 1 | A side read strobe |
| a_wr | output | 1 | A side write strobe |
| a_rdata | input | 8 | A side read data, same cycle |
| a_wdata | output | 8 | A side write data |
| b_addr | output | 8 | B register select |
| b_rd | output | 1 | B side read strobe |
| b_wr | output | 1 | B side write strobe |
| b_rdata | input | 8 | B side read data, same cycle |
| b_wdata | output | 8 | B side write data |

## Verification
The assertions assume that nothing writes settings or a start mask while `cpu_halt` is high, because a halted processor cannot issue such writes. They also assume that read data on both sides is valid in the cycle of the read strobe. The stimulus follows both rules. It writes every setting and start mask only when the block is idle, and it waits until both the reference queue and `cpu_halt` have drained before it starts the next scenario. The bench models both sides as combinational functions of the address, so the returned data is always available in the cycle it is read.

// File: rtl/dma_seq_pkg.sv
`timescale 1ns/1ps
// Shared widths, field indices and types for the sequential byte mover.
// Assumes: byte-wide data on both sides and three address bytes on the A side.
package dma_seq_pkg;
    localparam int A_W = 24;   // A side address width
    localparam int B_W = 8;    // B side register select width
    localparam int N_W = 16;   // byte count width
    localparam int D_W = 8;    // data width

    // settings field indices (low nibble of cfg_addr)
    localparam logic [3:0] FLD_CTRL = 4'd0;
    localparam logic [3:0] FLD_BASE = 4'd1;
    localparam logic [3:0] FLD_A0   = 4'd2;
    localparam logic [3:0] FLD_A1   = 4'd3;
    localparam logic [3:0] FLD_A2   = 4'd4;
    localparam logic [3:0] FLD_N0   = 4'd5;
    localparam logic [3:0] FLD_N1   = 4'd6;

    typedef enum logic [1:0] {
        STEP_UP    = 2'b00,
        STEP_HOLD  = 2'b01,
        STEP_DOWN  = 2'b10,
        STEP_HOLD2 = 2'b11
    } step_e;

    typedef struct packed {
        logic           to_a;    // 1: B read, A write
        step_e          step;
        logic [2:0]     pat;
        logic [B_W-1:0] bbase;
        logic [A_W-1:0] abase;
        logic [N_W-1:0] cnt;
    } chan_cfg_t;

    // B register offset for byte index k (low two bits) under pattern code pat
    function automatic logic [1:0] unit_offset(input logic [2:0] pat, input logic [1:0] k);
        case (pat)
            3'd1, 3'd5: unit_offset = {1'b0, k[0]};
            3'd3, 3'd7: unit_offset = {1'b0, k[1]};
            3'd4:       unit_offset = k;
            default:    unit_offset = 2'd0;
        endcase
    endfunction
endpackage

// File: rtl/dma_seq_cfg.sv
`timescale 1ns/1ps
// Per-channel settings register file.
// Assumes: writes come only while the engine is idle; bits 6:5 of the control byte are reserved.
module dma_seq_cfg
    import dma_seq_pkg::*;
#(
    parameter  int NCH  = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [CH_W-1:0] ch,
    input  logic [3:0]      fld,
    input  logic [D_W-1:0]  wdata,
    output chan_cfg_t       cfg [NCH]
);
    logic unused_rsvd;
    assign unused_rsvd = ^wdata[6:5];

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        // store the addressed field of this channel
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cfg[g] <= '0;
            end else if (we && ch == CH_W'(g)) begin
                case (fld)
                    FLD_CTRL: begin
                        cfg[g].to_a <= wdata[7];
                        cfg[g].step <= step_e'(wdata[4:3]);
                        cfg[g].pat  <= wdata[2:0];
                    end
                    FLD_BASE: cfg[g].bbase        <= wdata;
                    FLD_A0:   cfg[g].abase[7:0]   <= wdata;
                    FLD_A1:   cfg[g].abase[15:8]  <= wdata;
                    FLD_A2:   cfg[g].abase[23:16] <= wdata;
                    FLD_N0:   cfg[g].cnt[7:0]     <= wdata;
                    FLD_N1:   cfg[g].cnt[15:8]    <= wdata;
                    default:  ;
                endcase
            end
        end

        // R9
        cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(we && ch == CH_W'(g)) |=> $stable(cfg[g]));
    end
endmodule

// File: rtl/dma_seq_pick.sv
`timescale 1ns/1ps
// Picks the lowest-numbered requesting channel.
// Assumes: any request vector; sel is meaningful only when any is high.
module dma_seq_pick #(
    parameter  int NCH  = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]  req,
    output logic            any,
    output logic [CH_W-1:0] sel
);
    // scan from the top so the lowest set bit wins
    always_comb begin
        any = |req;
        sel = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (req[i]) sel = CH_W'(i);
        end
    end
endmodule

// File: rtl/dma_seq_mover.sv
`timescale 1ns/1ps
// Runs one channel: holds the working A address, bytes left and unit index,
// and produces one byte move per cycle while active.
// Assumes: start is raised only while inactive.
module dma_seq_mover
    import dma_seq_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  chan_cfg_t      cfg_in,
    output logic           active,
    output logic           last,
    output logic           to_a,
    output logic [A_W-1:0] a_addr,
    output logic [B_W-1:0] b_addr
);
    localparam logic [N_W:0] FULL_N = {1'b1, {N_W{1'b0}}};
    localparam logic [N_W:0] ONE_N  = {{N_W{1'b0}}, 1'b1};

    logic [A_W-1:0] cur_a, next_a;
    logic [N_W:0]   left;
    logic [1:0]     k;
    step_e          step;
    logic [2:0]     pat;
    logic [B_W-1:0] bbase;

    // next A address from the step mode
    always_comb begin
        case (step)
            STEP_UP:   next_a = cur_a + 1'b1;
            STEP_DOWN: next_a = cur_a - 1'b1;
            default:   next_a = cur_a;
        endcase
    end

    // load a channel on start, then advance once per moved byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            cur_a  <= '0;
            left   <= '0;
            k      <= '0;
            step   <= STEP_UP;
            pat    <= '0;
            bbase  <= '0;
            to_a   <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            cur_a  <= cfg_in.abase;
            left   <= (cfg_in.cnt == '0) ? FULL_N : {1'b0, cfg_in.cnt};
            k      <= '0;
            step   <= cfg_in.step;
            pat    <= cfg_in.pat;
            bbase  <= cfg_in.bbase;
            to_a   <= cfg_in.to_a;
        end else if (active) begin
            left  <= left - 1'b1;
            k     <= k + 1'b1;
            cur_a <= next_a;
            if (left == ONE_N) active <= 1'b0;
        end
    end

    assign last   = active && (left == ONE_N);
    assign a_addr = cur_a;
    assign b_addr = bbase + B_W'(unit_offset(pat, k));

    // R8
    left_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> left != '0);

    // R6
    fixed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !last && step[0]) |=> $stable(a_addr));
endmodule

// File: rtl/dma_seq_engine.sv
`timescale 1ns/1ps
// Eight-channel sequential byte mover between a 24-bit space and 256 registers.
// Assumes: no settings or start writes while cpu_halt is high; both sides
// return read data in the cycle of the read strobe.
module dma_seq_engine
    import dma_seq_pkg::*;
#(
    parameter  int NCH  = 8,
    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic [CH_W+3:0] cfg_addr,
    input  logic [D_W-1:0]  cfg_wdata,
    input  logic            go_we,
    input  logic [NCH-1:0]  go_data,
    output logic            cpu_halt,
    output logic [NCH-1:0]  chan_pending,
    output logic [A_W-1:0]  a_addr,
    output logic            a_rd,
    output logic            a_wr,
    input  logic [D_W-1:0]  a_rdata,
    output logic [D_W-1:0]  a_wdata,
    output logic [B_W-1:0]  b_addr,
    output logic            b_rd,
    output logic            b_wr,
    input  logic [D_W-1:0]  b_rdata,
    output logic [D_W-1:0]  b_wdata
);
    chan_cfg_t       cfg [NCH];
    logic [NCH-1:0]  pending;
    logic [CH_W-1:0] sel, cur_ch;
    logic            any, active, last, to_a, start;

    dma_seq_cfg #(.NCH(NCH)) cfg_i (
        .clk(clk), .rst_n(rst_n), .we(cfg_we),
        .ch(cfg_addr[CH_W+3:4]), .fld(cfg_addr[3:0]),
        .wdata(cfg_wdata), .cfg(cfg)
    );

    dma_seq_pick #(.NCH(NCH)) pick_i (
        .req(pending), .any(any), .sel(sel)
    );

    assign start = any && !active;

    dma_seq_mover mover_i (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_in(cfg[sel]),
        .active(active), .last(last), .to_a(to_a),
        .a_addr(a_addr), .b_addr(b_addr)
    );

    // pending mask: loaded by a start write, one bit dropped per finished channel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= '0;
            cur_ch  <= '0;
        end else begin
            if (go_we)     pending         <= go_data;
            else if (last) pending[cur_ch] <= 1'b0;
            if (start)     cur_ch          <= sel;
        end
    end

    assign cpu_halt     = |pending;
    assign chan_pending = pending;
    assign a_rd         = active && !to_a;
    assign b_wr         = active && !to_a;
    assign b_rd         = active && to_a;
    assign a_wr         = active && to_a;
    assign b_wdata      = a_rdata;
    assign a_wdata      = b_rdata;

    // R3
    strobe_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd || a_wr || b_rd || b_wr) |-> cpu_halt);

    // R5
    dir_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_rd == b_wr) && (a_wr == b_rd) && !(a_rd && a_wr));

    // R4
    pend_no_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !go_we |=> (chan_pending & ~$past(chan_pending)) == '0);

    // R4
    pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        last |=> !chan_pending[$past(cur_ch)]);

    // R3
    pick_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> pending[sel] && ((pending & ((NCH'(1) << sel) - NCH'(1))) == '0));

    // R3 (input rule: a halted processor issues no writes)
    go_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> !go_we && !cfg_we);
endmodule

// File: tb/dma_seq_engine_tb_top.sv
`timescale 1ns/1ps
module dma_seq_engine_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [6:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        go_we = 1'b0;
    logic [7:0]  go_data = '0;
    logic        cpu_halt;
    logic [7:0]  chan_pending;
    logic [23:0] a_addr;
    logic        a_rd, a_wr, b_rd, b_wr;
    logic [7:0]  a_rdata, a_wdata, b_addr, b_rdata, b_wdata;

    always #2 clk = ~clk;

    dma_seq_engine dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .go_we(go_we), .go_data(go_data),
        .cpu_halt(cpu_halt), .chan_pending(chan_pending),
        .a_addr(a_addr), .a_rd(a_rd), .a_wr(a_wr), .a_rdata(a_rdata), .a_wdata(a_wdata),
        .b_addr(b_addr), .b_rd(b_rd), .b_wr(b_wr), .b_rdata(b_rdata), .b_wdata(b_wdata)
    );

    function automatic int fa(input int a);
        return (a ^ (a >> 8) ^ (a >> 16) ^ 'h5A) & 'hFF;
    endfunction
    function automatic int fb(input int b);
        return (b ^ 'hC3) & 'hFF;
    endfunction
    assign a_rdata = 8'(fa(int'(a_addr)));
    assign b_rdata = 8'(fb(int'(b_addr)));

    // B offset per pattern code, straight from R7
    function automatic int b_off(input int pat, input int k);
        if (pat == 4) return k % 4;
        if (pat == 1 || pat == 5) return k % 2;
        if (pat == 3 || pat == 7) return (k / 2) % 2;
        return 0;
    endfunction

    typedef struct {
        bit       mv;
        bit       dir;
        bit       halt;
        int       a;
        int       b;
        bit [7:0] pend;
    } exp_t;

    exp_t q[$];
    int m_ctrl[8], m_b[8], m_a[8], m_n[8];
    int checks = 0, errors = 0, nbytes = 0;
    bit mon_en = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg_wr(input int ch, input int fld, input int val);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 7'((ch << 4) | fld); cfg_wdata = 8'(val);
        case (fld)
            0: m_ctrl[ch] = val & 'h9F;
            1: m_b[ch] = val;
            2: m_a[ch] = (m_a[ch] & 'hFFFF00) | val;
            3: m_a[ch] = (m_a[ch] & 'hFF00FF) | (val << 8);
            4: m_a[ch] = (m_a[ch] & 'h00FFFF) | (val << 16);
            5: m_n[ch] = (m_n[ch] & 'hFF00) | val;
            6: m_n[ch] = (m_n[ch] & 'h00FF) | (val << 8);
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup(input int ch, input int ctrl, input int b, input int a, input int n);
        cfg_wr(ch, 0, ctrl);
        cfg_wr(ch, 1, b);
        cfg_wr(ch, 2, a & 'hFF);
        cfg_wr(ch, 3, (a >> 8) & 'hFF);
        cfg_wr(ch, 4, (a >> 16) & 'hFF);
        cfg_wr(ch, 5, n & 'hFF);
        cfg_wr(ch, 6, (n >> 8) & 'hFF);
    endtask

    // start write plus the reference sequence it must produce (R3, R4, R6, R7, R8)
    task automatic go(input int mask);
        bit [7:0] p;
        @(negedge clk);
        go_we = 1'b1; go_data = 8'(mask);
        nbytes = 0;
        p = 8'(mask);
        for (int ch = 0; ch < 8; ch++) begin
            if (p[ch]) begin
                int a, n, st;
                exp_t e;
                a = m_a[ch];
                n = (m_n[ch] == 0) ? 65536 : m_n[ch];
                st = (m_ctrl[ch] >> 3) & 3;
                e.mv = 0; e.dir = 0; e.halt = 1; e.a = 0; e.b = 0; e.pend = p;
                q.push_back(e);
                for (int k = 0; k < n; k++) begin
                    e.mv = 1; e.dir = m_ctrl[ch][7]; e.halt = 1; e.pend = p;
                    e.a = a; e.b = (m_b[ch] + b_off(m_ctrl[ch] & 7, k)) & 'hFF;
                    q.push_back(e);
                    if (st == 0) a = (a + 1) & 'hFFFFFF;
                    else if (st == 2) a = (a - 1) & 'hFFFFFF;
                end
                p[ch] = 1'b0;
            end
        end
        @(negedge clk);
        go_we = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    // per-cycle comparison against the reference queue, sampled after the edge
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (mon_en) begin
            if (q.size() != 0) e = q.pop_front();
            else begin
                e.mv = 0; e.dir = 0; e.halt = 0; e.a = 0; e.b = 0; e.pend = 0;
            end
            chk(cpu_halt == e.halt, "R3 halt", int'(cpu_halt), int'(e.halt));
            chk(chan_pending == e.pend, "R4 pending", int'(chan_pending), int'(e.pend));
            chk(a_rd == (e.mv && !e.dir) && b_wr == (e.mv && !e.dir), "R5 A-to-B strobes",
                int'({a_rd, b_wr}), int'(e.mv && !e.dir));
            chk(a_wr == (e.mv && e.dir) && b_rd == (e.mv && e.dir), "R5 B-to-A strobes",
                int'({a_wr, b_rd}), int'(e.mv && e.dir));
            if (e.mv) begin
                nbytes++;
                chk(int'(a_addr) == e.a, "R6 a_addr", int'(a_addr), e.a);
                chk(int'(b_addr) == e.b, "R7 b_addr", int'(b_addr), e.b);
                if (!e.dir) chk(int'(b_wdata) == fa(e.a), "R5 b_wdata", int'(b_wdata), fa(e.a));
                else        chk(int'(a_wdata) == fb(e.b), "R5 a_wdata", int'(a_wdata), fb(e.b));
            end
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin
            m_ctrl[i] = 0; m_b[i] = 0; m_a[i] = 0; m_n[i] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!cpu_halt && chan_pending == 0, "R1 halt/pending", int'({cpu_halt, chan_pending}), 0);
        chk(!a_rd && !a_wr && !b_rd && !b_wr, "R1 strobes", int'({a_rd, a_wr, b_rd, b_wr}), 0);
        mon_en = 1'b1;

        // R2: word pattern, plus a write to an unused field that must change nothing
        setup(0, 'h01, 'h18, 'h123456, 6);
        cfg_wr(0, 9, 'hFF);
        go('h01);
        wait_idle();
        chk(nbytes == 6, "R2 byte total", nbytes, 6);

        // R3: three channels in one start, with decrement, hold, increment and wraps
        setup(1, 'h93, 'h40, 'h000002, 9);
        setup(3, 'h08, 'hFE, 'hFFFFFE, 7);
        setup(6, 'h02, 'h10, 'hFFFFFE, 3);
        go('h4A);
        wait_idle();
        chk(nbytes == 19, "R3 byte total", nbytes, 19);

        // R7: remaining pattern codes, one with held A and B-to-A
        setup(2, 'h05, 'h20, 'h000100, 5);
        setup(4, 'h86, 'h30, 'h000200, 5);
        setup(5, 'h1F, 'h70, 'h000300, 5);
        setup(7, 'h00, 'hFF, 'h000400, 5);
        go('hB4);
        wait_idle();
        chk(nbytes == 20, "R7 byte total", nbytes, 20);

        // R9: restart channel 0 without rewriting it
        go('h01);
        wait_idle();
        chk(nbytes == 6, "R9 repeat total", nbytes, 6);

        // R10: empty start mask
        go('h00);
        repeat (4) begin
            @(negedge clk);
            chk(!cpu_halt, "R10 halt", int'(cpu_halt), 0);
        end
        chk(nbytes == 0, "R10 byte total", nbytes, 0);

        // R8: count of one, then count zero meaning 65536
        setup(5, 'h84, 'h50, 'h000010, 1);
        setup(7, 'h08, 'h22, 'h000100, 0);
        go('hA0);
        wait_idle();
        chk(nbytes == 65537, "R8 byte total", nbytes, 65537);

        mon_en = 1'b0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule